// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer that software controls through one write-only control register and reads through one status register. A control write carries a start count, a run command and a 7-bit key. After the watchdog has been enabled, it accepts a write only when that write's key is the bitwise complement of the key it holds. Any other write is discarded without effect. A stray or runaway write therefore cannot restart the watchdog by chance.

A slow tick enable moves the countdown, at about 760 ticks per second in the intended system. The tick is generated outside this block. When the count first runs out, the block raises a non-maskable interrupt and reloads a short grace count. If software does not service the watchdog before the grace count also runs out, the block sends a one-cycle request to the external reset controller. An accepted control write clears the interrupt stage and lowers the NMI.

Top module: `wdg_keyed_top`

## Requirements
- R1: A write with `bus_addr` = 0x40 targets the control register, and writes to any other address have no effect. A read with `rd_addr` = 0x44 returns the status word: bits [8:0] hold the current count, bit 16 is the running flag, bit 17 is the NMI-stage flag, and all other bits are 0. Every other read address returns 0.
- R2: Control write fields are laid out as follows. Bits [8:0] are the start count. Bit 8 is also the run command and, once stored, the enable. Bits [15:9] are the key. All other bits are ignored.
- R3: While the stored enable bit is 1, a control write whose key is not the bitwise complement of the stored key is ignored completely. The status, NMI and reset request are left as they would have been without the write.
- R4: An accepted control write stores the new value, leaves the NMI stage, and drives `nmi` low from the next cycle.
- R5: An accepted write with a start count of 0 loads the count as 256.
- R6: While running, each cycle with `tick` high lowers the count by one. The tick that arrives when the count is 1 is an expiry.
- R7: An accepted write with the run command at 0 loads the count and stops the watchdog. While stopped, ticks leave the count unchanged.
- R8: On an expiry outside the NMI stage, `nmi` goes high in the following cycle, the count is reloaded with the grace count (parameter, default 1), and the watchdog keeps running.
- R9: On an expiry inside the NMI stage, `rst_req` is high for exactly one cycle, the watchdog stops, the count becomes 0, and `nmi` stays high.
- R10: After reset the count is 0, the watchdog is stopped, `nmi` and `rst_req` are low, and the stored control value is 0. The next control write is therefore accepted whatever its key.
- R11: When an accepted control write and a tick fall in the same cycle, the write takes effect and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Write byte offset |
| bus_wdata | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| tick | input | 1 | Slow countdown enable, one cycle wide |
| nmi | output | 1 | Non-maskable interrupt, high in the NMI stage |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that `tick` and `bus_wr` are clean single-cycle strobes sampled at the clock edge. They also assume that the grace parameter is non-zero and fits in the count field, so a running watchdog never holds a count of 0. The stimulus drives every input between clock edges. Half of its random control writes carry the correct complement key and the rest carry arbitrary keys. Start counts are kept small, or at 256 and just above when the run bit is set. Tick density is high enough that both expiry stages are reached many times within the run.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int CNT_W    = 9;
    localparam int KEY_W    = 7;
    localparam int DATA_W   = 32;
    localparam int RUN_BIT  = 8;
    localparam int STAT_RUN = 16;
    localparam int STAT_NMI = 17;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [CNT_W-1:0] cnt;   // cnt[RUN_BIT] doubles as run/enable
    } wd_ctrl_t;

    typedef enum logic {
        STG_NORMAL = 1'b0,
        STG_NMI    = 1'b1
    } wd_stage_e;

    function automatic wd_ctrl_t unpack_ctrl(input logic [DATA_W-1:0] v);
        wd_ctrl_t c;
        c.cnt = v[CNT_W-1:0];
        c.key = v[CNT_W+KEY_W-1:CNT_W];
        return c;
    endfunction

    function automatic logic key_ok(input wd_ctrl_t stored, input wd_ctrl_t incoming);
        logic [KEY_W-1:0] want;
        want = ~stored.key;
        return (!stored.cnt[RUN_BIT]) || (incoming.key == want);
    endfunction

    function automatic logic [CNT_W-1:0] start_count(input wd_ctrl_t c);
        logic [CNT_W-1:0] full;
        full = CNT_W'(256);
        return (c.cnt == '0) ? full : c.cnt;
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input logic [CNT_W-1:0] cnt,
                                                      input logic running,
                                                      input wd_stage_e stage);
        logic [DATA_W-1:0] s;
        s = '0;
        s[CNT_W-1:0] = cnt;
        s[STAT_RUN]  = running;
        s[STAT_NMI]  = (stage == STG_NMI);
        return s;
    endfunction

endpackage

// File: rtl/wdg_keygate.sv
module wdg_keygate
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              accept,
    output wd_ctrl_t          new_ctrl,
    output wd_ctrl_t          ctrl_q
);

    assign new_ctrl = unpack_ctrl(wdata);
    assign accept   = ctrl_wr && key_ok(ctrl_q, new_ctrl);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (accept) begin
            ctrl_q <= new_ctrl;
        end
    end

    assert_reject_keeps_ctrl_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !accept) |=> $stable(ctrl_q));

    assert_disabled_takes_any_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !ctrl_q.cnt[RUN_BIT]) |-> accept);

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int GRACE = 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  wd_ctrl_t         new_ctrl,
    input  logic             tick,
    input  wd_stage_e        stage,
    output logic [CNT_W-1:0] cnt_q,
    output logic             running_q,
    output logic             expire
);

    localparam logic [CNT_W-1:0] GRACE_CNT = CNT_W'(GRACE);

    assign expire = running_q && tick && !accept && (cnt_q <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            running_q <= 1'b0;
        end else if (accept) begin
            cnt_q     <= start_count(new_ctrl);
            running_q <= new_ctrl.cnt[RUN_BIT];
        end else if (expire) begin
            if (stage == STG_NORMAL) begin
                cnt_q <= GRACE_CNT;
            end else begin
                cnt_q     <= '0;
                running_q <= 1'b0;
            end
        end else if (running_q && tick) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assert_tick_decrements_R6: assert property (@(posedge clk) disable iff (rst)
        (running_q && tick && !accept && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    assert_stopped_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (!running_q && !accept) |=> ($stable(cnt_q) && !running_q));

    assert_load_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        accept |=> (cnt_q != '0));

endmodule

// File: rtl/wdg_stage.sv
module wdg_stage
    import wdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  logic      expire,
    output wd_stage_e stage_q,
    output logic      nmi,
    output logic      rst_req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= STG_NORMAL;
            rst_req <= 1'b0;
        end else begin
            rst_req <= expire && (stage_q == STG_NMI);
            if (accept) begin
                stage_q <= STG_NORMAL;
            end else if (expire) begin
                stage_q <= STG_NMI;
            end
        end
    end

    assign nmi = (stage_q == STG_NMI);

    assert_accept_clears_nmi_R4: assert property (@(posedge clk) disable iff (rst)
        accept |=> !nmi);

    assert_rst_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    assert_rst_in_nmi_R9: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> nmi);

    assert_nmi_from_expiry_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi) |-> $past(expire));

endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top
    import wdg_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          GRACE    = 1,
    parameter logic [7:0]  CTRL_OFS = 8'h40,
    parameter logic [7:0]  STAT_OFS = 8'h44
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              tick,
    output logic              nmi,
    output logic              rst_req
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    logic             ctrl_wr;
    logic             accept;
    wd_ctrl_t         new_ctrl;
    wd_ctrl_t         ctrl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             running_q;
    logic             expire;
    wd_stage_e        stage_q;

    assign ctrl_wr = bus_wr && (bus_addr == CTRL_A);

    wdg_keygate u_gate (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .wdata    (bus_wdata),
        .accept   (accept),
        .new_ctrl (new_ctrl),
        .ctrl_q   (ctrl_q)
    );

    wdg_counter #(.GRACE(GRACE)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .new_ctrl  (new_ctrl),
        .tick      (tick),
        .stage     (stage_q),
        .cnt_q     (cnt_q),
        .running_q (running_q),
        .expire    (expire)
    );

    wdg_stage u_stage (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .expire  (expire),
        .stage_q (stage_q),
        .nmi     (nmi),
        .rst_req (rst_req)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == STAT_A) begin
            rd_data = pack_status(cnt_q, running_q, stage_q);
        end
    end

    assert_reject_no_effect_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ctrl_q.cnt[RUN_BIT] && !accept && !tick) |=> ($stable(cnt_q) && $stable(nmi)));

endmodule

// File: tb/tb_wdg_keyed_top.sv
module tb_wdg_keyed_top;

    localparam int GRACE = 1;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [7:0]  rd_addr;
    logic [31:0] rd_data;
    logic        tick;
    logic        nmi;
    logic        rst_req;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state
    logic [15:0] m_ctrl;
    logic [8:0]  m_cnt;
    logic        m_run;
    logic        m_stage;
    logic        m_rst;

    always #2.5 clk = ~clk;

    wdg_keyed_top #(.GRACE(GRACE)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick(tick), .nmi(nmi), .rst_req(rst_req)
    );

    function automatic logic [31:0] exp_status(input logic [8:0] c, input logic r, input logic s);
        logic [31:0] v;
        v = '0;
        v[8:0] = c;
        v[16]  = r;
        v[17]  = s;
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // advance the model by one clock with the given inputs
    task automatic model_step(input logic wr, input logic [7:0] a, input logic [31:0] d, input logic tk);
        logic acc;
        logic [6:0] want;
        want = ~m_ctrl[15:9];
        acc = wr && (a == 8'h40) && (!m_ctrl[8] || d[15:9] == want);
        m_rst = 1'b0;
        if (acc) begin
            m_ctrl  = d[15:0];
            m_stage = 1'b0;
            m_cnt   = (d[8:0] == 9'd0) ? 9'd256 : d[8:0];
            m_run   = d[8];
        end else if (m_run && tk) begin
            if (m_cnt > 9'd1) m_cnt = m_cnt - 9'd1;
            else if (!m_stage) begin
                m_stage = 1'b1;
                m_cnt   = 9'(GRACE);
            end else begin
                m_rst = 1'b1;
                m_run = 1'b0;
                m_cnt = 9'd0;
            end
        end
    endtask

    // drive one cycle, update model, check after the edge
    task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic tk, input string req);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; tick = tk;
        @(posedge clk);
        model_step(wr, a, d, tk);
        #1;
        bus_wr = 1'b0; tick = 1'b0;
        chk({req, " status"}, rd_data, exp_status(m_cnt, m_run, m_stage));
        chk({req, " nmi"}, {31'd0, nmi}, {31'd0, m_stage});
        chk({req, " rst_req"}, {31'd0, rst_req}, {31'd0, m_rst});
    endtask

    function automatic logic [31:0] mkw(input logic [6:0] key, input logic [8:0] cnt);
        return {16'h0, key, cnt};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog timeout");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        rst = 1'b1; bus_wr = 0; bus_addr = 0; bus_wdata = 0; tick = 0; rd_addr = 8'h44;
        m_ctrl = 0; m_cnt = 0; m_run = 0; m_stage = 0; m_rst = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R10 reset state
        chk("R10 reset status", rd_data, 32'h0);
        chk("R10 reset nmi", {31'd0, nmi}, 32'd0);
        chk("R10 reset rst_req", {31'd0, rst_req}, 32'd0);

        // R1 other read address returns 0
        rd_addr = 8'h40; #1;
        chk("R1 ctrl read zero", rd_data, 32'h0);
        rd_addr = 8'h44;

        // R7 stopped load, ticks ignored
        cyc(1, 8'h40, mkw(7'h15, 9'd5), 0, "R7 load stopped");
        chk("R7 count 5", rd_data, exp_status(9'd5, 0, 0));
        cyc(0, 0, 0, 1, "R7 tick ignored");
        chk("R7 unchanged", rd_data, exp_status(9'd5, 0, 0));

        // R5 zero count loads 256 (stopped, any key since disabled)
        cyc(1, 8'h40, mkw(7'h33, 9'd0), 0, "R5 zero count");
        chk("R5 256", rd_data, exp_status(9'd256, 0, 0));

        // R1 write elsewhere ignored
        cyc(1, 8'h48, mkw(7'h00, 9'h105), 0, "R1 foreign write");
        chk("R1 foreign write ignored", rd_data, exp_status(9'd256, 0, 0));

        // R2 start, key 0x2A, count 256+2
        cyc(1, 8'h40, mkw(7'h2A, 9'h102), 0, "R2 start");
        chk("R2 running 258", rd_data, exp_status(9'd258, 1, 0));

        // R3 wrong key ignored
        cyc(1, 8'h40, mkw(7'h2A, 9'h001), 0, "R3 wrong key");
        chk("R3 ignored", rd_data, exp_status(9'd258, 1, 0));

        // R11 correct key with a tick in the same cycle
        cyc(1, 8'h40, mkw(7'h55, 9'h101), 1, "R11 write beats tick");
        chk("R11 count 257", rd_data, exp_status(9'd257, 1, 0));

        // R6 / R8 run to expiry
        for (int i = 0; i < 256; i++) cyc(0, 0, 0, 1, "R6 countdown");
        chk("R6 count 1", rd_data, exp_status(9'd1, 1, 0));
        cyc(0, 0, 0, 1, "R8 first expiry");
        chk("R8 nmi high", {31'd0, nmi}, 32'd1);
        chk("R8 grace loaded", rd_data, exp_status(9'(GRACE), 1, 1));

        // R4 service clears NMI (next key = ~0x55 = 0x2A)
        cyc(1, 8'h40, mkw(7'h2A, 9'h100), 0, "R4 service");
        chk("R4 nmi low", {31'd0, nmi}, 32'd0);

        // R9 two expiries -> reset pulse
        for (int i = 0; i < 256; i++) cyc(0, 0, 0, 1, "R8 to nmi");
        for (int i = 0; i < GRACE - 1; i++) cyc(0, 0, 0, 1, "R9 grace");
        cyc(0, 0, 0, 1, "R9 final expiry");
        chk("R9 rst_req pulse", {31'd0, rst_req}, 32'd1);
        cyc(0, 0, 0, 1, "R9 pulse ends");
        chk("R9 single cycle", {31'd0, rst_req}, 32'd0);
        chk("R9 stopped nmi held", rd_data, exp_status(9'd0, 0, 1));

        // random phase
        for (int i = 0; i < 30000; i++) begin
            logic        w;
            logic [7:0]  a;
            logic [31:0] d;
            logic [8:0]  c;
            logic [6:0]  k;
            w = ($urandom % 40) == 0;
            a = (($urandom % 8) == 0) ? 8'h48 : 8'h40;
            c = ($urandom % 2) ? (9'h100 | 9'($urandom % 6)) : 9'($urandom % 6);
            k = ($urandom % 2) ? ~m_ctrl[15:9] : 7'($urandom);
            d = {$urandom} & 32'hFFFF_0000;
            d[15:0] = {k, c};
            cyc(w, a, d, ($urandom % 3) != 0, "R3 R6 R8 R9 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule